// File: doc/BRIEF.md
# Wrapping Address Register Unit

This unit keeps the pointer state for a signal-processing datapath: four 16-bit address registers. Each one has its own signed stride register and its own wrap-mask register. An instruction decoder presents a small operation code that names one address register and one of four update kinds: hold, step down by one, step up by one, or add the paired stride. The unit computes the updated pointer in the same cycle and shows it on `nxt_addr` next to the unmodified pointer on `cur_addr`.

The new pointer is written back only when the writeback stage raises `commit`, so a pipeline can compute a result and apply it later. A nonzero mask confines the low bits of the pointer to a circular window whose size is a power of two. The high bits stay fixed as the window base. A mask of zero turns wrapping off and the unit does plain modulo-2^16 arithmetic. Three load strobes share one data bus and one register select, and they let the surrounding core set any address, stride or mask register directly.

There is no multi-cycle sequencing. The only enumerated type is the update kind, which selects among four datapath results.

Top module: `addr_wrap_unit`

## Requirements
- R1: After reset, all address, stride and mask registers read zero on `ar_flat`, `ix_flat` and `wp_flat`. Register n occupies bits [16n+15:16n] of each flat bus.
- R2: In `op_code`, bits [1:0] select the register and bits [3:2] select the kind: 00 hold, 01 step down, 10 step up, 11 add stride. `cur_addr` shows the selected address register, and `nxt_addr` is computed from that register and its paired stride and mask in the same cycle.
- R3: Step down with a nonzero mask m gives `a | m` when `a & m` is zero, and `a - 1` otherwise.
- R4: Step up with a nonzero mask m gives `a & ~m` when `a & m` equals m, and `a + 1` otherwise.
- R5: Add stride with a nonzero mask m gives `(a & ~m) | ((a + s) & m)`, where s is the paired stride read as a signed 16-bit value. The bits outside the mask never change.
- R6: With a mask of zero, the three update kinds give `a - 1`, `a + 1` and `a + s` modulo 2^16.
- R7: The hold kind gives `nxt_addr` equal to `cur_addr`, and committing it leaves every register unchanged.
- R8: When `commit` is high at a clock edge, the selected address register takes `nxt_addr`. No other address register changes because of the commit.
- R9: `ld_ar`, `ld_ix` and `ld_wp` each write `ld_data` into register `ld_sel` of their bank at the clock edge. They may be combined with each other, and with a commit to a different register, in the same cycle.
- R10: When `ld_ar` and `commit` target the same address register in the same cycle, the loaded value wins.
- R11: When neither `commit` nor `ld_ar` is high, every address register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Update kind [3:2] and register select [1:0] |
| commit | input | 1 | Write `nxt_addr` into the selected address register |
| ld_ar | input | 1 | Load `ld_data` into address register `ld_sel` |
| ld_ix | input | 1 | Load `ld_data` into stride register `ld_sel` |
| ld_wp | input | 1 | Load `ld_data` into mask register `ld_sel` |
| ld_sel | input | 2 | Register number for the loads |
| ld_data | input | 16 | Load data |
| cur_addr | output | 16 | Selected address register before update |
| nxt_addr | output | 16 | Updated pointer for the selected register |
| ar_flat | output | 64 | All address registers |
| ix_flat | output | 64 | All stride registers |
| wp_flat | output | 64 | All mask registers |

## Verification
The directed cases cover the following boundaries:

- **Window floor on step down.** A unit that only subtracted would leave the window instead of jumping to its top.
- **Window top on step up.** A unit that mirrored the step-down rule incorrectly would carry into the base bits.
- **Negative and overflowing strides.** A unit that added without masking would corrupt the base.
- **Zero mask.** A unit that applied the wrap rule literally would freeze the pointer at the same value or snap it to zero.
- **Load and commit to the same register in one cycle.** A unit with the wrong priority would keep the computed pointer instead of the loaded one.

Random traffic mixes contiguous and arbitrary masks with random loads and commits. After every edge it compares all three banks, which exposes any stray write to an unselected register.

// File: rtl/addr_wrap_pkg.sv
package addr_wrap_pkg;
    // Update kinds carried in the upper bits of the operation code.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_DEC  = 2'b01,
        STEP_INC  = 2'b10,
        STEP_IDX  = 2'b11
    } step_kind_e;
endpackage

// File: rtl/addr_wrap_step.sv
module addr_wrap_step
    import addr_wrap_pkg::*;
#(
    parameter int AW = 16
) (
    input  step_kind_e      kind,
    input  logic [AW-1:0]   cur,
    input  logic [AW-1:0]   idx,
    input  logic [AW-1:0]   mask,
    output logic [AW-1:0]   nxt
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic          wrap_off;
    logic [AW-1:0] base;
    logic [AW-1:0] sum;
    logic          at_floor;
    logic          at_top;

    assign wrap_off = (mask == '0);
    assign base     = cur & ~mask;
    assign sum      = cur + idx;
    assign at_floor = ((cur & mask) == '0);
    assign at_top   = ((cur & mask) == mask);

    always_comb begin
        nxt = cur;
        unique case (kind)
            STEP_HOLD: nxt = cur;
            STEP_DEC:  nxt = (!wrap_off && at_floor) ? (cur | mask) : (cur - ONE);
            STEP_INC:  nxt = (!wrap_off && at_top)   ? base         : (cur + ONE);
            STEP_IDX:  nxt = wrap_off ? sum : (base | (sum & mask));
        endcase
    end
endmodule

// File: rtl/addr_wrap_bank.sv
module addr_wrap_bank #(
    parameter int AW   = 16,
    parameter int NREG = 4,
    localparam int SELW = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pri_en,
    input  logic [SELW-1:0]      pri_sel,
    input  logic [AW-1:0]        pri_data,
    input  logic                 sec_en,
    input  logic [SELW-1:0]      sec_sel,
    input  logic [AW-1:0]        sec_data,
    output logic [NREG*AW-1:0]   flat
);
    // The primary write port has priority over the secondary port per entry.
    for (genvar i = 0; i < NREG; i++) begin : g_ent
        logic [AW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (pri_en && (pri_sel == SELW'(i))) begin
                q <= pri_data;
            end else if (sec_en && (sec_sel == SELW'(i))) begin
                q <= sec_data;
            end
        end
        assign flat[i*AW +: AW] = q;
    end
endmodule

// File: rtl/addr_wrap_unit.sv
module addr_wrap_unit
    import addr_wrap_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREG = 4,
    localparam int SELW = $clog2(NREG),
    localparam int OPW  = SELW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OPW-1:0]       op_code,
    input  logic                 commit,
    input  logic                 ld_ar,
    input  logic                 ld_ix,
    input  logic                 ld_wp,
    input  logic [SELW-1:0]      ld_sel,
    input  logic [AW-1:0]        ld_data,
    output logic [AW-1:0]        cur_addr,
    output logic [AW-1:0]        nxt_addr,
    output logic [NREG*AW-1:0]   ar_flat,
    output logic [NREG*AW-1:0]   ix_flat,
    output logic [NREG*AW-1:0]   wp_flat
);
    logic [SELW-1:0] sel;
    step_kind_e      kind;
    logic [AW-1:0]   sel_ix;
    logic [AW-1:0]   sel_wp;

    assign sel      = op_code[SELW-1:0];
    assign kind     = step_kind_e'(op_code[OPW-1:SELW]);
    assign cur_addr = ar_flat[sel*AW +: AW];
    assign sel_ix   = ix_flat[sel*AW +: AW];
    assign sel_wp   = wp_flat[sel*AW +: AW];

    addr_wrap_step #(.AW(AW)) u_step (
        .kind (kind),
        .cur  (cur_addr),
        .idx  (sel_ix),
        .mask (sel_wp),
        .nxt  (nxt_addr)
    );

    // Address bank: direct load beats commit on the same entry.
    addr_wrap_bank #(.AW(AW), .NREG(NREG)) u_ar (
        .clk      (clk),
        .rst_n    (rst_n),
        .pri_en   (ld_ar),
        .pri_sel  (ld_sel),
        .pri_data (ld_data),
        .sec_en   (commit),
        .sec_sel  (sel),
        .sec_data (nxt_addr),
        .flat     (ar_flat)
    );

    addr_wrap_bank #(.AW(AW), .NREG(NREG)) u_ix (
        .clk      (clk),
        .rst_n    (rst_n),
        .pri_en   (ld_ix),
        .pri_sel  (ld_sel),
        .pri_data (ld_data),
        .sec_en   (1'b0),
        .sec_sel  ('0),
        .sec_data ('0),
        .flat     (ix_flat)
    );

    addr_wrap_bank #(.AW(AW), .NREG(NREG)) u_wp (
        .clk      (clk),
        .rst_n    (rst_n),
        .pri_en   (ld_wp),
        .pri_sel  (ld_sel),
        .pri_data (ld_data),
        .sec_en   (1'b0),
        .sec_sel  ('0),
        .sec_data ('0),
        .flat     (wp_flat)
    );
endmodule

// File: rtl/addr_wrap_checker.sv
module addr_wrap_checker
    import addr_wrap_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREG = 4,
    localparam int SELW = $clog2(NREG),
    localparam int OPW  = SELW + 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [OPW-1:0]       op_code,
    input logic                 commit,
    input logic                 ld_ar,
    input logic [SELW-1:0]      ld_sel,
    input logic [AW-1:0]        ld_data,
    input logic [AW-1:0]        cur_addr,
    input logic [AW-1:0]        nxt_addr,
    input logic [NREG*AW-1:0]   ar_flat,
    input logic [NREG*AW-1:0]   wp_flat
);
    logic [SELW-1:0] sel;
    logic [1:0]      kind;
    logic [AW-1:0]   cwp;

    assign sel  = op_code[SELW-1:0];
    assign kind = op_code[OPW-1:SELW];
    assign cwp  = wp_flat[sel*AW +: AW];

    logic            ld_v, cm_v;
    logic [SELW-1:0] ld_s, cm_s;
    logic [AW-1:0]   ld_d, cm_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_v <= 1'b0;
            cm_v <= 1'b0;
            ld_s <= '0;
            cm_s <= '0;
            ld_d <= '0;
            cm_d <= '0;
        end else begin
            ld_v <= ld_ar;
            ld_s <= ld_sel;
            ld_d <= ld_data;
            cm_v <= commit && !(ld_ar && (ld_sel == sel));
            cm_s <= sel;
            cm_d <= nxt_addr;
        end
    end

    AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'b01 && cwp != '0 && (cur_addr & cwp) == '0) |-> nxt_addr == (cur_addr | cwp)); // R3
    AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'b10 && cwp != '0 && (cur_addr & cwp) == cwp) |-> nxt_addr == (cur_addr & ~cwp)); // R4
    AST_IDX_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'b11 && cwp != '0) |-> (nxt_addr & ~cwp) == (cur_addr & ~cwp)); // R5
    AST_HOLD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'b00) |-> nxt_addr == cur_addr); // R7
    AST_COMMIT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        cm_v |-> ar_flat[cm_s*AW +: AW] == cm_d); // R8
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_v |-> ar_flat[ld_s*AW +: AW] == ld_d); // R10
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !ld_ar) |=> $stable(ar_flat)); // R11
endmodule

bind addr_wrap_unit addr_wrap_checker #(.AW(AW), .NREG(NREG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_code  (op_code),
    .commit   (commit),
    .ld_ar    (ld_ar),
    .ld_sel   (ld_sel),
    .ld_data  (ld_data),
    .cur_addr (cur_addr),
    .nxt_addr (nxt_addr),
    .ar_flat  (ar_flat),
    .wp_flat  (wp_flat)
);

// File: tb/addr_wrap_unit_test.sv
module addr_wrap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic        commit = 1'b0, ld_ar = 1'b0, ld_ix = 1'b0, ld_wp = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] cur_addr, nxt_addr;
    logic [63:0] ar_flat, ix_flat, wp_flat;

    always #2 clk = ~clk;

    addr_wrap_unit uut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .commit(commit),
        .ld_ar(ld_ar), .ld_ix(ld_ix), .ld_wp(ld_wp), .ld_sel(ld_sel),
        .ld_data(ld_data), .cur_addr(cur_addr), .nxt_addr(nxt_addr),
        .ar_flat(ar_flat), .ix_flat(ix_flat), .wp_flat(wp_flat)
    );

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_ar [4], m_ix [4], m_wp [4];

    // Expected pointer from the requirement formulas.
    function automatic logic [15:0] f_next(logic [1:0] k, logic [15:0] a, logic [15:0] s, logic [15:0] w);
        logic [15:0] t;
        t = a + s;
        case (k)
            2'd0: return a;
            2'd1: begin
                if (w != 16'h0 && (a & w) == 16'h0) return a | w;
                return a - 16'd1;
            end
            2'd2: begin
                if (w != 16'h0 && (a & w) == w) return a & ~w;
                return a + 16'd1;
            end
            default: begin
                if (w == 16'h0) return t;
                return (a & ~w) | (t & w);
            end
        endcase
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        for (int r = 0; r < 4; r++) begin
            chk(tag, ar_flat[r*16 +: 16], m_ar[r]);
            chk(tag, ix_flat[r*16 +: 16], m_ix[r]);
            chk(tag, wp_flat[r*16 +: 16], m_wp[r]);
        end
    endtask

    // Update the model from the current inputs, cross an edge, clear strobes.
    task automatic tick();
        logic [15:0] nv;
        logic [1:0]  s;
        s  = op_code[1:0];
        nv = f_next(op_code[3:2], m_ar[s], m_ix[s], m_wp[s]);
        if (commit) m_ar[s] = nv;
        if (ld_ar)  m_ar[ld_sel] = ld_data;
        if (ld_ix)  m_ix[ld_sel] = ld_data;
        if (ld_wp)  m_wp[ld_sel] = ld_data;
        @(posedge clk);
        @(negedge clk);
        commit = 0; ld_ar = 0; ld_ix = 0; ld_wp = 0;
    endtask

    task automatic load(int bank, int r, logic [15:0] d);
        ld_sel = 2'(r); ld_data = d;
        ld_ar = (bank == 0); ld_ix = (bank == 1); ld_wp = (bank == 2);
        tick();
    endtask

    task automatic try_op(string tag, logic [3:0] op, logic [15:0] exp);
        op_code = op;
        #1;
        chk(tag, nxt_addr, exp);
        chk("R2", cur_addr, m_ar[op[1:0]]);
        commit = 1;
        tick();
        chk_all("R8");
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        for (int r = 0; r < 4; r++) begin
            m_ar[r] = '0; m_ix[r] = '0; m_wp[r] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_all("R1");

        // Windowed register 1, 16-entry window at 0x0120.
        load(2, 1, 16'h000F);
        load(0, 1, 16'h0120);
        try_op("R3", 4'b0101, 16'h012F);
        try_op("R4", 4'b1001, 16'h0120);
        load(0, 1, 16'h0125);
        try_op("R3", 4'b0101, 16'h0124);
        load(1, 1, 16'hFFFD);
        load(0, 1, 16'h0121);
        try_op("R5", 4'b1101, 16'h012E);
        load(1, 1, 16'h0005);
        load(0, 1, 16'h012C);
        try_op("R5", 4'b1101, 16'h0121);

        // Register 2 without a window.
        try_op("R6", 4'b0110, 16'hFFFF);
        try_op("R6", 4'b1010, 16'h0000);
        load(1, 2, 16'h8000);
        load(0, 2, 16'h9000);
        try_op("R6", 4'b1110, 16'h1000);

        // Hold kind.
        try_op("R7", 4'b0001, m_ar[1]);
        chk_all("R7");

        // Load and commit to the same register: load wins.
        op_code = 4'b1001; commit = 1;
        ld_ar = 1; ld_sel = 2'd1; ld_data = 16'h5555;
        tick();
        chk_all("R10");
        chk("R10", ar_flat[31:16], 16'h5555);

        // Load and commit to different registers: both land.
        op_code = 4'b1011; commit = 1;
        ld_ar = 1; ld_ix = 1; ld_sel = 2'd0; ld_data = 16'h1111;
        tick();
        chk_all("R9");

        // No commit, no address load: addresses hold.
        op_code = 4'b0100;
        ld_wp = 1; ld_sel = 2'd0; ld_data = 16'h0003;
        tick();
        chk_all("R11");

        // Random mix.
        seed = $urandom(32'h5EED_1234);
        for (int it = 0; it < 400; it++) begin
            logic [3:0]  op;
            logic [15:0] e;
            string       tg;
            op = 4'($urandom);
            op_code = op;
            commit = 1'($urandom);
            ld_sel = 2'($urandom);
            ld_ar = ($urandom % 4) == 0;
            ld_ix = ($urandom % 4) == 0;
            ld_wp = ($urandom % 5) == 0;
            if (ld_wp && ($urandom % 2 == 0))
                ld_data = 16'((32'd1 << ($urandom % 17)) - 1);
            else
                ld_data = 16'($urandom);
            e = f_next(op[3:2], m_ar[op[1:0]], m_ix[op[1:0]], m_wp[op[1:0]]);
            if (m_wp[op[1:0]] == 16'h0 && op[3:2] != 2'b00) tg = "R6";
            else case (op[3:2])
                2'b00: tg = "R7";
                2'b01: tg = "R3";
                2'b10: tg = "R4";
                default: tg = "R5";
            endcase
            #1;
            chk(tg, nxt_addr, e);
            chk("R2", cur_addr, m_ar[op[1:0]]);
            tick();
            chk_all("R8");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule